// File: doc/BRIEF.md
# Address-Extended Bank Register File

This block holds an 11-bit bank number for a cartridge I/O page and answers CPU reads of it. A single store instruction sets the whole number. The data byte supplies the low eight bits. Which of eight adjacent byte offsets was written supplies the upper three. Software that wants bank N therefore indexes the store address by N's upper bits and writes N's lower byte.

Readback is split across two address ranges. The low byte reads back at any of the eight store offsets. The upper three bits read back on the low data lines of the next eight offsets, with every other data bit held at 0. A mode input blanks all readback, for example while the flash is driven by hand. Stores still land while that input is high.

The number of implemented upper bank bits is a parameter, so smaller device capacities tie the unused upper bits to 0.

Top module: `xbank_regfile`

## Requirements
- R1: A write strobe with page select high at offset 0x00 to 0x07 loads the data byte into bank bits 7:0 on the next rising clock edge.
- R2: The same write loads offset bits 2:0 into bank bits 10:8. A write at offset 0x03 with data 0x3C gives bank 0x33C.
- R3: Writes at any offset from 0x08 to 0xFF leave the bank unchanged. So do writes made while page select is low. There are no mirrors of the eight store offsets.
- R4: A read at any offset 0x00 to 0x07 drives bank bits 7:0 on the read data and raises the output-enable.
- R5: A read at any offset 0x08 to 0x0F drives bank bits 10:8 on data bits 2:0, with data bits 7:3 at 0, and raises the output-enable.
- R6: A read at any offset from 0x10 to 0xFF leaves the output-enable low and the read data at 0x00.
- R7: While the readback-mute input is high, every read leaves the output-enable low and the read data at 0x00.
- R8: Writes at offsets 0x00 to 0x07 take effect while the readback-mute input is high.
- R9: Reset (rst_n low) clears all eleven bank bits to 0.
- R10: With HI_IMPL upper bits implemented, bank bits at position 8+HI_IMPL and above stay 0, both on the bank output and on readback.
- R11: The output-enable is low and the read data is 0x00 unless page select and the read strobe are both high.
- R12: The bank output keeps its old value until the rising edge that ends the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_sel | input | 1 | I/O page select |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte offset within the I/O page |
| wdata | input | 8 | Write data |
| readback_mute | input | 1 | High blanks all readback |
| bank | output | 11 | Current bank number |
| rdata | output | 8 | Read data |
| rdata_oe | output | 1 | Read data output-enable |

## Verification
The bench builds two copies that share one bus. The first uses the default HI_IMPL of 3, so it covers every store offset and the full 11-bit range. The second uses HI_IMPL of 1, so a store at offset 0x07 shows the upper two bank bits forced to 0 on both the bank output and the upper-bits readback.

// File: rtl/xbank_pkg.sv
package xbank_pkg;
    localparam int LO_W   = 8;
    localparam int HI_W   = 3;
    localparam int BANK_W = LO_W + HI_W;
    localparam int ADR_W  = 8;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } bank_t;
endpackage

// File: rtl/xbank_decode.sv
module xbank_decode
    import xbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_sel,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [ADR_W-1:0] addr,
    output logic             wr_hit,
    output logic             rd_lo_hit,
    output logic             rd_hi_hit
);
    localparam int SEL_W = ADR_W - HI_W;

    logic [SEL_W-1:0] upper;
    logic             in_store;
    logic             in_hi;

    always_comb begin
        upper     = addr[ADR_W-1:HI_W];
        in_store  = (upper == SEL_W'(0));
        in_hi     = (upper == SEL_W'(1));
        wr_hit    = io_sel && wr_en && in_store;
        rd_lo_hit = io_sel && rd_en && in_store;
        rd_hi_hit = io_sel && rd_en && in_hi;
    end

    // R6
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[ADR_W-1:4] != '0) |-> !(rd_lo_hit || rd_hi_hit));

    // R4
    rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_lo_hit, rd_hi_hit}));
endmodule

// File: rtl/xbank_store.sv
module xbank_store
    import xbank_pkg::*;
#(
    parameter int HI_IMPL = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [LO_W-1:0] lo_in,
    input  logic [HI_W-1:0] hi_in,
    output bank_t           bank_o
);
    logic [HI_W-1:0] hi_mask;

    genvar gi;
    generate
        for (gi = 0; gi < HI_W; gi++) begin : g_mask
            if (gi < HI_IMPL) begin : g_on
                assign hi_mask[gi] = 1'b1;
            end else begin : g_off
                assign hi_mask[gi] = 1'b0;
            end
        end
    endgenerate

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.lo = lo_in;
            st_d.hi = hi_in & hi_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bank_o = st_q;

    // R1
    lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (st_q.lo == $past(lo_in)));

    // R2
    hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (st_q.hi == ($past(hi_in) & hi_mask)));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(st_q));
endmodule

// File: rtl/xbank_readmux.sv
module xbank_readmux
    import xbank_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_lo_hit,
    input  logic            rd_hi_hit,
    input  logic            mute,
    input  bank_t           bank_i,
    output logic [LO_W-1:0] rdata,
    output logic            oe
);
    always_comb begin
        oe    = (rd_lo_hit || rd_hi_hit) && !mute;
        rdata = '0;
        if (oe) begin
            if (rd_lo_hit) rdata = bank_i.lo;
            else           rdata = {{(LO_W-HI_W){1'b0}}, bank_i.hi};
        end
    end

    // R7
    mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mute |-> (!oe && rdata == '0));

    // R5
    hi_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && rd_hi_hit) |-> (rdata[LO_W-1:HI_W] == '0));

    // R11
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (rdata == '0));
endmodule

// File: rtl/xbank_regfile.sv
module xbank_regfile
    import xbank_pkg::*;
#(
    parameter int HI_IMPL = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        addr,
    input  logic [7:0]        wdata,
    input  logic              readback_mute,
    output logic [10:0]       bank,
    output logic [7:0]        rdata,
    output logic              rdata_oe
);
    logic  wr_hit, rd_lo_hit, rd_hi_hit;
    bank_t bank_s;

    xbank_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_sel    (io_sel),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wr_hit    (wr_hit),
        .rd_lo_hit (rd_lo_hit),
        .rd_hi_hit (rd_hi_hit)
    );

    xbank_store #(.HI_IMPL(HI_IMPL)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_hit),
        .lo_in  (wdata),
        .hi_in  (addr[HI_W-1:0]),
        .bank_o (bank_s)
    );

    xbank_readmux u_rmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_lo_hit (rd_lo_hit),
        .rd_hi_hit (rd_hi_hit),
        .mute      (readback_mute),
        .bank_i    (bank_s),
        .rdata     (rdata),
        .oe        (rdata_oe)
    );

    assign bank = bank_s;

    // R8
    mute_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (readback_mute && io_sel && wr_en && addr[7:3] == 5'd0)
            |=> (bank[7:0] == $past(wdata)));
endmodule

// File: tb/xbank_regfile_test.sv
`timescale 1ns/1ps
module xbank_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0, mute = 1'b0;
    logic [7:0]  addr = '0, wdata = '0;
    logic [10:0] bank, bank_s;
    logic [7:0]  rdata, rdata_s;
    logic        oe, oe_s;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    xbank_regfile uut (
        .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .readback_mute(mute),
        .bank(bank), .rdata(rdata), .rdata_oe(oe));

    xbank_regfile #(.HI_IMPL(1)) uut_small (
        .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .readback_mute(mute),
        .bank(bank_s), .rdata(rdata_s), .rdata_oe(oe_s));

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input logic sel = 1'b1);
        @(negedge clk);
        io_sel = sel; wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        io_sel = 1'b0; wr_en = 1'b0;
        #1;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic sel = 1'b1, input logic rd = 1'b1);
        @(negedge clk);
        io_sel = sel; rd_en = rd; wr_en = 1'b0; addr = a;
        #1;
    endtask

    task automatic bus_idle();
        @(negedge clk);
        io_sel = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        check("R9 bank after reset", 16'(bank), 16'h000);
        check("R11 oe idle", 16'(oe), 16'h0);
        bus_read(8'h00); check("R9 lo readback", 16'(rdata), 16'h00);
        bus_read(8'h08); check("R9 hi readback", 16'(rdata), 16'h00);
        bus_idle();
    endtask

    task automatic t_write_patterns();
        bus_write(8'h00, 8'hA5); check("R1 store off0", 16'(bank), 16'h0A5);
        bus_write(8'h03, 8'h3C); check("R2 store off3", 16'(bank), 16'h33C);
        bus_write(8'h07, 8'hFF); check("R2 store off7", 16'(bank), 16'h7FF);
        bus_write(8'h05, 8'h00); check("R1 store off5 zero", 16'(bank), 16'h500);
    endtask

    task automatic t_timing();
        @(negedge clk);
        io_sel = 1'b1; wr_en = 1'b1; addr = 8'h01; wdata = 8'h77;
        #1; check("R12 before edge", 16'(bank), 16'h500);
        @(negedge clk);
        io_sel = 1'b0; wr_en = 1'b0;
        #1; check("R12 after edge", 16'(bank), 16'h177);
    endtask

    task automatic t_readback();
        bus_write(8'h06, 8'h81);
        for (int i = 0; i < 8; i++) begin
            bus_read(8'(i));
            check("R4 lo data", 16'(rdata), 16'h81);
            check("R4 lo oe", 16'(oe), 16'h1);
        end
        for (int i = 8; i < 16; i++) begin
            bus_read(8'(i));
            check("R5 hi data", 16'(rdata), 16'h06);
            check("R5 hi oe", 16'(oe), 16'h1);
        end
        bus_idle();
    endtask

    task automatic t_no_mirror();
        bus_write(8'h08, 8'h12); check("R3 write 08", 16'(bank), 16'h681);
        bus_write(8'h0F, 8'h34); check("R3 write 0F", 16'(bank), 16'h681);
        bus_write(8'h10, 8'h56); check("R3 write 10", 16'(bank), 16'h681);
        bus_write(8'hF8, 8'h78); check("R3 write F8", 16'(bank), 16'h681);
        bus_write(8'h02, 8'h9A, 1'b0); check("R3 write unselected", 16'(bank), 16'h681);
    endtask

    task automatic t_unmapped_read();
        bus_read(8'h10); check("R6 oe 10", 16'(oe), 16'h0); check("R6 data 10", 16'(rdata), 16'h00);
        bus_read(8'h80); check("R6 oe 80", 16'(oe), 16'h0);
        bus_read(8'hFF); check("R6 oe FF", 16'(oe), 16'h0); check("R6 data FF", 16'(rdata), 16'h00);
        bus_idle();
    endtask

    task automatic t_strobes();
        bus_read(8'h00, 1'b1, 1'b0); check("R11 no rd strobe oe", 16'(oe), 16'h0);
        check("R11 no rd strobe data", 16'(rdata), 16'h00);
        bus_read(8'h08, 1'b0, 1'b1); check("R11 no select oe", 16'(oe), 16'h0);
        check("R11 no select data", 16'(rdata), 16'h00);
        bus_idle();
    endtask

    task automatic t_mute();
        mute = 1'b1;
        bus_read(8'h00); check("R7 muted lo oe", 16'(oe), 16'h0); check("R7 muted lo data", 16'(rdata), 16'h00);
        bus_read(8'h08); check("R7 muted hi oe", 16'(oe), 16'h0); check("R7 muted hi data", 16'(rdata), 16'h00);
        bus_idle();
        bus_write(8'h02, 8'h44); check("R8 write while muted", 16'(bank), 16'h244);
        mute = 1'b0;
        bus_read(8'h00); check("R8 readback after mute", 16'(rdata), 16'h44);
        bus_read(8'h08); check("R8 hi readback after mute", 16'(rdata), 16'h02);
        bus_idle();
    endtask

    task automatic t_small();
        bus_write(8'h07, 8'h5A);
        check("R10 full bank", 16'(bank), 16'h75A);
        check("R10 small bank", 16'(bank_s), 16'h15A);
        bus_read(8'h08); check("R10 small hi readback", 16'(rdata_s), 16'h01);
        bus_idle();
        bus_write(8'h06, 8'h11); check("R10 small bank off6", 16'(bank_s), 16'h011);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1; t_reset_pre: begin end
        rst_n = 1'b1;
        t_reset();
        t_write_patterns();
        t_timing();
        t_readback();
        t_no_mirror();
        t_unmapped_read();
        t_strobes();
        t_mute();
        t_small();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=timeout exp=done");
            finish_run();
        end
    end
endmodule